// File: doc/BRIEF.md
# Asynchronous SRAM Bus Cycle Controller

This block sits between a synchronous host and an external 8K x 8 asynchronous static RAM. The host raises a request with a read/write select, a 13-bit address and, for writes, a data byte. The controller then steps the RAM's active-low chip enable, output enable and write enable through a fixed sequence of phases. Each phase lasts a whole number of system clock cycles.

Every phase length comes from a nanosecond limit and the clock period. The limits are address setup, write pulse, data setup, data hold, access time, output-enable access, read cycle, write recovery and output turn-off. The nanosecond value is rounded up to whole cycles, with a floor of one cycle. The data bus is exposed pad-side as an output byte, an output-enable and an input byte. The pad ring combines them into the bidirectional pins.

A write runs through four phases: address setup, then a combined chip-enable/write-enable pulse, then data hold, then a recovery gap. A read holds chip enable and output enable low for the access count. It samples the input byte on the last access cycle and then waits out a turn-off gap. The controller returns a one-cycle done pulse to the host and accepts no new request until the gap has elapsed.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, chip enable, output enable and write enable are all high, the data output-enable is low, ready is high and done is low.
- R2: A read accepted on a clock edge holds chip enable and output enable low, with write enable high, for ACC cycles starting on the next cycle. ACC is the largest of the rounded access time, output-enable access time and read cycle time.
- R3: A read samples the data input on the last access cycle. Done is high for exactly the one following cycle, and the read data output holds the sampled byte from that cycle onward.
- R4: A write first spends AS cycles with all strobes high and the address driven. Chip enable and write enable then fall together and stay low for WP cycles, where WP is the larger of the rounded write-pulse and data-setup times.
- R5: Output enable stays high during every cycle of a write.
- R6: The data output-enable is high from the first pulse cycle through DH cycles after write enable rises, and low at all other times. While it is high, the data output equals the host's write byte.
- R7: The RAM address equals the accepted host address and does not change from acceptance until ready returns.
- R8: A write's done pulse comes in the first cycle after its hold phase. The recovery gap lasts WR cycles after a write and OD cycles after a read, with all strobes high. Ready is low from acceptance until the gap ends.
- R9: A request presented while ready is low has no effect: no strobe changes, the address does not move, and memory is not written.
- R10: Each interval is the smallest whole number of clock cycles that covers its nanosecond limit, and never less than one cycle. A 0 ns limit therefore gives one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Request; accepted on a clock edge where ready is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 13 | Byte address |
| host_wdata | input | 8 | Write byte |
| host_ready | output | 1 | Controller idle, request will be taken |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Last byte read |
| sram_addr | output | 13 | RAM address bus |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dq_out | output | 8 | Data toward the RAM |
| sram_dq_oe | output | 1 | Drive enable for the data pins |
| sram_dq_in | input | 8 | Data from the RAM pins |

## Verification
Call the edge that accepts a request cycle 0. With the default 10 ns clock, a read holds its strobes in cycles 1 to 7, raises done with the captured byte in cycle 8, and shows ready again in cycle 11. A write shows one setup cycle, a six-cycle pulse in cycles 2 to 7, a hold cycle in 8, done in 9 and ready in 10. Each scenario task samples every port on the falling clock edge between these register updates. It compares each sample against a window the bench computes from its own rounding function. A separate task measures phase lengths purely from port transitions.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W_SETUP,
    ST_W_PULSE,
    ST_W_HOLD,
    ST_R_ACCESS,
    ST_GAP
  } bus_state_e;

  // Round a nanosecond limit up to whole clock cycles, at least one.
  function automatic int ns_to_cycles(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Bits needed to hold values 0..v.
  function automatic int bits_for(input int v);
    int w;
    w = $clog2(v + 1);
    if (w < 1) w = 1;
    return w;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          phase_done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign phase_done = (cnt == '0);

  // R10
  timer_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && phase_done) |=> phase_done);

endmodule

// File: rtl/sram_bus_fsm.sv
module sram_bus_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CW      = 4,
  parameter int AS_CYC  = 1,
  parameter int WP_CYC  = 6,
  parameter int DH_CYC  = 1,
  parameter int ACC_CYC = 7,
  parameter int WR_CYC  = 1,
  parameter int OD_CYC  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_we,
  input  logic          phase_done,
  output logic          timer_load,
  output logic [CW-1:0] timer_val,
  output logic          ready,
  output logic          accept,
  output logic          capture,
  output logic          write_done,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          dq_oe
);

  localparam logic [CW-1:0] AS_M1  = CW'(AS_CYC - 1);
  localparam logic [CW-1:0] WP_M1  = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] DH_M1  = CW'(DH_CYC - 1);
  localparam logic [CW-1:0] ACC_M1 = CW'(ACC_CYC - 1);
  localparam logic [CW-1:0] WR_M1  = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] OD_M1  = CW'(OD_CYC - 1);

  bus_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:     if (req)        state_nx = req_we ? ST_W_SETUP : ST_R_ACCESS;
      ST_W_SETUP:  if (phase_done) state_nx = ST_W_PULSE;
      ST_W_PULSE:  if (phase_done) state_nx = ST_W_HOLD;
      ST_W_HOLD:   if (phase_done) state_nx = ST_GAP;
      ST_R_ACCESS: if (phase_done) state_nx = ST_GAP;
      ST_GAP:      if (phase_done) state_nx = ST_IDLE;
      default:                     state_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    case (state_nx)
      ST_W_SETUP:  timer_val = AS_M1;
      ST_W_PULSE:  timer_val = WP_M1;
      ST_W_HOLD:   timer_val = DH_M1;
      ST_R_ACCESS: timer_val = ACC_M1;
      ST_GAP:      timer_val = (state == ST_R_ACCESS) ? OD_M1 : WR_M1;
      default:     timer_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end

  assign timer_load = (state_nx != state);
  assign ready      = (state == ST_IDLE);
  assign accept     = ready && req;
  assign capture    = (state == ST_R_ACCESS) && phase_done;
  assign write_done = (state == ST_W_HOLD) && phase_done;

  assign ce_n  = !((state == ST_W_PULSE) || (state == ST_R_ACCESS));
  assign we_n  = (state != ST_W_PULSE);
  assign oe_n  = (state != ST_R_ACCESS);
  assign dq_oe = (state == ST_W_PULSE) || (state == ST_W_HOLD);

  // R8
  gap_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    write_done |=> (ce_n && we_n && !dq_oe && !ready));

  // R2
  read_strobe_pair_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (!ce_n && we_n));

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_AS_NS       = 0,
  parameter int T_WP_NS       = 55,
  parameter int T_DS_NS       = 30,
  parameter int T_DH_NS       = 0,
  parameter int T_ACC_NS      = 70,
  parameter int T_OE_NS       = 35,
  parameter int T_RC_NS       = 70,
  parameter int T_WR_NS       = 5,
  parameter int T_OD_NS       = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic              host_done,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int AS_CYC  = ns_to_cycles(T_AS_NS, CLK_PERIOD_NS);
  localparam int WP_CYC  = max_of(ns_to_cycles(T_WP_NS, CLK_PERIOD_NS),
                                  ns_to_cycles(T_DS_NS, CLK_PERIOD_NS));
  localparam int DH_CYC  = ns_to_cycles(T_DH_NS, CLK_PERIOD_NS);
  localparam int ACC_CYC = max_of(max_of(ns_to_cycles(T_ACC_NS, CLK_PERIOD_NS),
                                         ns_to_cycles(T_OE_NS, CLK_PERIOD_NS)),
                                  ns_to_cycles(T_RC_NS, CLK_PERIOD_NS));
  localparam int WR_CYC  = ns_to_cycles(T_WR_NS, CLK_PERIOD_NS);
  localparam int OD_CYC  = ns_to_cycles(T_OD_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC = max_of(max_of(max_of(AS_CYC, WP_CYC), max_of(DH_CYC, ACC_CYC)),
                                  max_of(WR_CYC, OD_CYC));
  localparam int CW      = bits_for(MAX_CYC);

  logic          timer_load;
  logic [CW-1:0] timer_val;
  logic          phase_done;
  logic          accept;
  logic          capture;
  logic          write_done;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load       (timer_load),
    .load_val   (timer_val),
    .phase_done (phase_done)
  );

  sram_bus_fsm #(
    .CW(CW), .AS_CYC(AS_CYC), .WP_CYC(WP_CYC), .DH_CYC(DH_CYC),
    .ACC_CYC(ACC_CYC), .WR_CYC(WR_CYC), .OD_CYC(OD_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req        (host_req),
    .req_we     (host_we),
    .phase_done (phase_done),
    .timer_load (timer_load),
    .timer_val  (timer_val),
    .ready      (host_ready),
    .accept     (accept),
    .capture    (capture),
    .write_done (write_done),
    .ce_n       (sram_ce_n),
    .oe_n       (sram_oe_n),
    .we_n       (sram_we_n),
    .dq_oe      (sram_dq_oe)
  );

  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr  <= '0;
      wdata_q    <= '0;
      host_rdata <= '0;
      host_done  <= 1'b0;
    end else begin
      if (accept) begin
        sram_addr <= host_addr;
        wdata_q   <= host_wdata;
      end
      if (capture) host_rdata <= sram_dq_in;
      host_done <= capture || write_done;
    end
  end

  assign sram_dq_out = wdata_q;

  // Run length of the write-enable pulse, for the width check.
  logic [CW-1:0] we_lo_run;
  always_ff @(posedge clk) begin
    if (rst)             we_lo_run <= '0;
    else if (!sram_we_n) we_lo_run <= we_lo_run + 1'b1;
    else                 we_lo_run <= '0;
  end

  // R4
  wp_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (we_lo_run == CW'(WP_CYC)));

  // R5
  oe_quiet_in_write_chk: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> (sram_oe_n && sram_dq_oe));

  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> sram_oe_n);

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!host_ready && $past(!host_ready)) |-> $stable(sram_addr));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    host_done |=> !host_done);

  // R8
  busy_after_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |=> !host_ready);

endmodule

// File: tb/tb_sram_cycle_ctrl.sv
module tb_sram_cycle_ctrl;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        host_req;
  logic        host_we;
  logic [12:0] host_addr;
  logic [7:0]  host_wdata;
  logic        host_ready;
  logic        host_done;
  logic [7:0]  host_rdata;
  logic [12:0] sram_addr;
  logic        sram_ce_n;
  logic        sram_oe_n;
  logic        sram_we_n;
  logic [7:0]  sram_dq_out;
  logic        sram_dq_oe;
  logic [7:0]  sram_dq_in;

  int vectors = 0;
  int misses  = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  sram_cycle_ctrl #(.CLK_PERIOD_NS(PERIOD)) dut (
    .clk(clk), .rst(rst),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ready(host_ready), .host_done(host_done),
    .host_rdata(host_rdata), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  // Small RAM model: 64 bytes, aliased on the low address bits.
  logic [7:0] mem [64];
  logic [7:0] shadow [64];
  assign sram_dq_in = (!sram_ce_n && !sram_oe_n && sram_we_n) ? mem[sram_addr[5:0]] : 8'hEE;
  always @(posedge clk) if (!sram_ce_n && !sram_we_n) mem[sram_addr[5:0]] <= sram_dq_out;

  // Bench restatement of the rounding rule: smallest k >= 1 with k*PERIOD >= ns.
  function automatic int cyc(input int ns);
    int k = 1;
    while (k * PERIOD < ns) k++;
    return k;
  endfunction

  int AS, WP, DH, ACC, WR, OD;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(sram_ce_n == 1'b1, "R1 ce_n", sram_ce_n, 1);
    check(sram_oe_n == 1'b1, "R1 oe_n", sram_oe_n, 1);
    check(sram_we_n == 1'b1, "R1 we_n", sram_we_n, 1);
    check(sram_dq_oe == 1'b0, "R1 dq_oe", sram_dq_oe, 0);
    check(host_ready == 1'b1, "R1 ready", host_ready, 1);
    check(host_done == 1'b0, "R1 done", host_done, 0);
  endtask

  task automatic t_read(input logic [12:0] a, input bit noisy, input logic [12:0] na);
    int total = ACC + OD;
    logic [7:0] exp_b = shadow[a[5:0]];
    host_req = 1'b1; host_we = 1'b0; host_addr = a;
    for (int n = 0; n <= total; n++) begin
      @(negedge clk);
      if (n == 0) begin
        if (noisy) begin host_we = 1'b1; host_addr = na; host_wdata = 8'h5A; end
        else host_req = 1'b0;
      end
      if (noisy && n == total - 1) host_req = 1'b0;
      check(sram_ce_n == !(n < ACC), "R2 ce_n", sram_ce_n, !(n < ACC));
      check(sram_oe_n == !(n < ACC), "R2 oe_n", sram_oe_n, !(n < ACC));
      check(sram_we_n == 1'b1, noisy ? "R9 we_n" : "R2 we_n", sram_we_n, 1);
      check(sram_dq_oe == 1'b0, "R6 dq_oe read", sram_dq_oe, 0);
      check(host_done == (n == ACC), "R3 done", host_done, n == ACC);
      if (n == ACC) check(host_rdata == exp_b, "R3 rdata", host_rdata, exp_b);
      check(host_ready == (n == total), "R8 ready read", host_ready, n == total);
      if (n < total) check(sram_addr == a, noisy ? "R9 addr" : "R7 addr", sram_addr, a);
    end
  endtask

  task automatic t_write(input logic [12:0] a, input logic [7:0] d);
    int total = AS + WP + DH + WR;
    bit pulse, hold;
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    for (int n = 0; n <= total; n++) begin
      @(negedge clk);
      if (n == 0) begin host_req = 1'b0; host_wdata = ~d; end
      pulse = (n >= AS) && (n < AS + WP);
      hold  = (n >= AS + WP) && (n < AS + WP + DH);
      check(sram_we_n == !pulse, "R4 we_n", sram_we_n, !pulse);
      check(sram_ce_n == !pulse, "R4 ce_n", sram_ce_n, !pulse);
      check(sram_oe_n == 1'b1, "R5 oe_n", sram_oe_n, 1);
      check(sram_dq_oe == (pulse || hold), "R6 dq_oe", sram_dq_oe, pulse || hold);
      if (pulse || hold) check(sram_dq_out == d, "R6 dq_out", sram_dq_out, d);
      if (n < total) check(sram_addr == a, "R7 addr", sram_addr, a);
      check(host_done == (n == AS + WP + DH), "R8 done write", host_done, n == AS + WP + DH);
      check(host_ready == (n == total), "R8 ready write", host_ready, n == total);
    end
    shadow[a[5:0]] = d;
  endtask

  // Measure the phase lengths of a write purely from port transitions.
  task automatic t_measure(input logic [12:0] a, input logic [7:0] d);
    int setup_n = 0, pulse_n = 0, hold_n = 0, gap_n = 0;
    bit seen_pulse = 1'b0;
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0;
    for (int guard = 0; guard < 100 && !host_ready; guard++) begin
      if (!sram_we_n) begin pulse_n++; seen_pulse = 1'b1; end
      else if (!seen_pulse) setup_n++;
      else if (sram_dq_oe) hold_n++;
      else gap_n++;
      @(negedge clk);
    end
    check(setup_n == cyc(0), "R10 setup 0ns", setup_n, cyc(0));
    check(pulse_n == ((cyc(55) > cyc(30)) ? cyc(55) : cyc(30)), "R10 pulse", pulse_n, cyc(55));
    check(hold_n == cyc(0), "R10 hold 0ns", hold_n, cyc(0));
    check(gap_n == cyc(5), "R10 gap 5ns", gap_n, cyc(5));
    shadow[a[5:0]] = d;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    AS = cyc(0); WP = (cyc(55) > cyc(30)) ? cyc(55) : cyc(30); DH = cyc(0);
    ACC = cyc(70); if (cyc(35) > ACC) ACC = cyc(35);
    WR = cyc(5); OD = cyc(25);
    for (int i = 0; i < 64; i++) begin
      mem[i] = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    rst = 1'b1; host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_read(13'h0004, 1'b0, '0);
    t_write(13'h0004, 8'hC3);
    t_read(13'h0004, 1'b0, '0);
    t_write(13'h1FFF, 8'h00);
    t_write(13'h0000, 8'hFF);
    t_read(13'h1FFF, 1'b0, '0);
    t_read(13'h0000, 1'b0, '0);
    t_read(13'h0011, 1'b1, 13'h0025);
    t_read(13'h0025, 1'b0, '0);
    check(host_rdata == 8'(37 * 7 + 3), "R9 untouched byte", host_rdata, 8'(37 * 7 + 3));
    t_measure(13'h0A0A, 8'h96);
    t_read(13'h0A0A, 1'b0, '0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule